// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is a byte-wide arithmetic and logic unit organised around a working accumulator. Each accepted command takes an operand byte read from a register file, an immediate byte, an operation code, a destination select and a bit index. The block performs the operation against the accumulator and updates a five-flag status register. It returns the result together with a strobe that names where the result belongs: the accumulator or the file register. The caller performs the write-back into the file register.

Commands arrive on a valid/ready channel, and results leave on a second valid/ready channel. The output is a single register. A command is accepted only when that register is empty or is being emptied in the same cycle, so `cmd_ready` equals `!res_valid || res_ready`. While `res_valid` is high and `res_ready` is low, the output payload is held unchanged and no new command is taken. A command is accepted on a rising clock edge where both `cmd_valid` and `cmd_ready` are high. Its result, the new accumulator value and the new flags all appear after that same edge.

Operation codes on `cmd_op`:
- 0: add immediate
- 1: add file operand
- 2: add file operand with carry
- 3: AND immediate
- 4: AND file operand
- 5: clear a bit of the file operand
- 6 and 7: reserved

Status bit positions on `flags`:
- bit 0: carry
- bit 1: half carry, out of bit 3
- bit 2: zero
- bit 3: signed overflow
- bit 4: negative

Top module: `acc_alu`

## Requirements
- R1: After reset, `acc` is 0x00, `flags` is 0, and `res_valid` is 0.
- R2: Op 0 produces `acc + cmd_imm`. The result is written to the accumulator, with `res_to_acc`=1 and `res_to_file`=0.
- R3: Op 1 produces `acc + cmd_file`. When `cmd_dest`=0, the result goes to the accumulator (`res_to_acc`=1). When `cmd_dest`=1, the result is returned for the file register (`res_to_file`=1), and the accumulator is unchanged.
- R4: Op 2 produces `acc + cmd_file + carry`, where carry is flag bit 0 before the command. The destination follows `cmd_dest` as in R3.
- R5: The add ops (0, 1, 2) set all five flags from the operation:
  - carry (bit 0) is the carry out of bit 7;
  - half carry (bit 1) is the carry out of bit 3;
  - zero (bit 2) is set when the 8-bit result is zero;
  - overflow (bit 3) is set when both operands share a sign bit and the result's sign bit differs from it;
  - negative (bit 4) equals result bit 7.
- R6: Op 3 produces `acc & cmd_imm` into the accumulator. Op 4 produces `acc & cmd_file`, with the destination following `cmd_dest`. Both AND ops update only negative and zero, and leave carry, half carry and overflow unchanged.
- R7: Op 5 returns `cmd_file` with bit `cmd_bit` forced to 0. It sets `res_to_file`=1, and leaves both the accumulator and the flags unchanged.
- R8: While `res_valid`=1 and `res_ready`=0, the result payload holds, `cmd_ready` is 0, and no command alters the accumulator or the flags.
- R9: Reserved ops 6 and 7 are accepted and return data 0 with both strobes at 0. They leave the accumulator and the flags unchanged.
- R10: `res_to_acc` and `res_to_file` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is present |
| cmd_ready | output | 1 | The block can take a command this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_file | input | 8 | Operand byte read from the file register |
| cmd_imm | input | 8 | Immediate byte |
| cmd_dest | input | 1 | Destination for file ops: 0 accumulator, 1 file register |
| cmd_bit | input | 3 | Bit index for the bit-clear op |
| res_valid | output | 1 | A result is held |
| res_ready | input | 1 | The consumer takes the result |
| res_data | output | 8 | Result byte |
| res_to_acc | output | 1 | The result was written to the accumulator |
| res_to_file | output | 1 | The result must be written to the file register |
| acc | output | 8 | Accumulator contents |
| flags | output | 5 | Status flags: N, OV, Z, DC, C from bit 4 down to bit 0 |

## Verification
Both the accumulator and the flags feed every later command. A corrupted accumulator shows up directly on `acc` right after the accepting edge, and again in the very next result. A stale or wrongly merged flag bit can hide until a later command reads it. Carry is read by the add-with-carry op. The preserved bits are exposed when an AND op follows an add. For these reasons the tests chain commands, so that each one starts from the state left by the one before. A handshake fault shows up within one cycle of back-pressure, as a changed payload or an accepted command.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD_IMM  = 3'd0,
    OP_ADD_FILE = 3'd1,
    OP_ADC_FILE = 3'd2,
    OP_AND_IMM  = 3'd3,
    OP_AND_FILE = 3'd4,
    OP_BIT_CLR  = 3'd5,
    OP_RSV_6    = 3'd6,
    OP_RSV_7    = 3'd7
  } alu_op_e;

  localparam int FLAG_W  = 5;
  localparam int FL_C    = 0;
  localparam int FL_DC   = 1;
  localparam int FL_Z    = 2;
  localparam int FL_OV   = 3;
  localparam int FL_N    = 4;

  typedef struct packed {
    logic use_imm;
    logic use_carry;
    logic is_add;
    logic is_and;
    logic is_bclr;
    logic to_acc;
    logic to_file;
  } alu_ctl_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [2:0] op,
  input  logic       dest,
  output alu_ctl_t   ctl
);
  always_comb begin
    ctl = '0;
    unique case (alu_op_e'(op))
      OP_ADD_IMM: begin
        ctl.use_imm = 1'b1;
        ctl.is_add  = 1'b1;
        ctl.to_acc  = 1'b1;
      end
      OP_ADD_FILE: begin
        ctl.is_add  = 1'b1;
        ctl.to_acc  = ~dest;
        ctl.to_file = dest;
      end
      OP_ADC_FILE: begin
        ctl.is_add    = 1'b1;
        ctl.use_carry = 1'b1;
        ctl.to_acc    = ~dest;
        ctl.to_file   = dest;
      end
      OP_AND_IMM: begin
        ctl.use_imm = 1'b1;
        ctl.is_and  = 1'b1;
        ctl.to_acc  = 1'b1;
      end
      OP_AND_FILE: begin
        ctl.is_and  = 1'b1;
        ctl.to_acc  = ~dest;
        ctl.to_file = dest;
      end
      OP_BIT_CLR: begin
        ctl.is_bclr = 1'b1;
        ctl.to_file = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
  parameter int DW  = 8,
  parameter int NIB = 4
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          c_out,
  output logic          hc_out,
  output logic          ovf
);
  logic [DW:0]  full;
  logic [NIB:0] low;

  always_comb begin
    full   = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    low    = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
    sum    = full[DW-1:0];
    c_out  = full[DW];
    hc_out = low[NIB];
    ovf    = (a[DW-1] == b[DW-1]) && (full[DW-1] != a[DW-1]);
  end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_ctl_t            ctl,
  input  logic [DW-1:0]       result,
  input  logic                add_c,
  input  logic                add_hc,
  input  logic                add_ov,
  input  logic [FLAG_W-1:0]   old_flags,
  output logic [FLAG_W-1:0]   new_flags
);
  logic neg, zero;

  always_comb begin
    neg       = result[DW-1];
    zero      = (result == '0);
    new_flags = old_flags;
    if (ctl.is_add) begin
      new_flags[FL_C]  = add_c;
      new_flags[FL_DC] = add_hc;
      new_flags[FL_OV] = add_ov;
      new_flags[FL_N]  = neg;
      new_flags[FL_Z]  = zero;
    end else if (ctl.is_and) begin
      new_flags[FL_N]  = neg;
      new_flags[FL_Z]  = zero;
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter  int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [DW-1:0]     cmd_file,
  input  logic [DW-1:0]     cmd_imm,
  input  logic              cmd_dest,
  input  logic [BW-1:0]     cmd_bit,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DW-1:0]     res_data,
  output logic              res_to_acc,
  output logic              res_to_file,
  output logic [DW-1:0]     acc,
  output logic [FLAG_W-1:0] flags
);
  alu_ctl_t          ctl;
  logic [DW-1:0]     opnd_b, add_sum, and_res, clr_res, mask, result;
  logic              add_c, add_hc, add_ov, accept;
  logic [FLAG_W-1:0] next_flags;
  logic [DW-1:0]     acc_q;
  logic [FLAG_W-1:0] flags_q;

  acc_alu_decode u_dec (
    .op   (cmd_op),
    .dest (cmd_dest),
    .ctl  (ctl)
  );

  assign opnd_b = ctl.use_imm ? cmd_imm : cmd_file;

  acc_alu_adder #(.DW(DW), .NIB(4)) u_add (
    .a      (acc_q),
    .b      (opnd_b),
    .cin    (ctl.use_carry & flags_q[FL_C]),
    .sum    (add_sum),
    .c_out  (add_c),
    .hc_out (add_hc),
    .ovf    (add_ov)
  );

  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign mask[i] = (cmd_bit != BW'(i));
  end

  assign and_res = acc_q & opnd_b;
  assign clr_res = cmd_file & mask;

  always_comb begin
    result = '0;
    if (ctl.is_add)       result = add_sum;
    else if (ctl.is_and)  result = and_res;
    else if (ctl.is_bclr) result = clr_res;
  end

  acc_alu_flags #(.DW(DW)) u_flags (
    .ctl       (ctl),
    .result    (result),
    .add_c     (add_c),
    .add_hc    (add_hc),
    .add_ov    (add_ov),
    .old_flags (flags_q),
    .new_flags (next_flags)
  );

  assign cmd_ready = ~res_valid | res_ready;
  assign accept    = cmd_valid & cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_to_acc  <= 1'b0;
      res_to_file <= 1'b0;
      acc_q       <= '0;
      flags_q     <= '0;
    end else if (accept) begin
      res_valid   <= 1'b1;
      res_data    <= result;
      res_to_acc  <= ctl.to_acc;
      res_to_file <= ctl.to_file;
      flags_q     <= next_flags;
      if (ctl.to_acc) acc_q <= result;
    end else if (res_ready) begin
      res_valid   <= 1'b0;
    end
  end

  assign acc   = acc_q;
  assign flags = flags_q;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter  int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [BW-1:0]     cmd_bit,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DW-1:0]     res_data,
  input logic              res_to_acc,
  input logic              res_to_file,
  input logic [DW-1:0]     acc,
  input logic [FLAG_W-1:0] flags
);
  logic took;
  assign took = cmd_valid && cmd_ready;

  a_r10_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot0({res_to_acc, res_to_file}));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) &&
      $stable(res_to_acc) && $stable(res_to_file) && $stable(acc) && $stable(flags)));

  a_r2_acc_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_to_acc) |-> (acc == res_data));

  a_r6_and_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (took && (cmd_op == 3'd3 || cmd_op == 3'd4)) |=>
      ($stable(flags[FL_C]) && $stable(flags[FL_DC]) && $stable(flags[FL_OV])));

  a_r7_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (took && cmd_op == 3'd5) |=>
      ($stable(flags) && $stable(acc) && res_to_file && (res_data[$past(cmd_bit)] == 1'b0)));

  a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (took && cmd_op[2:1] == 2'b11) |=>
      ($stable(acc) && $stable(flags) && !res_to_acc && !res_to_file));
endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_op      (cmd_op),
  .cmd_bit     (cmd_bit),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_data    (res_data),
  .res_to_acc  (res_to_acc),
  .res_to_file (res_to_file),
  .acc         (acc),
  .flags       (flags)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_file = '0;
  logic [7:0] cmd_imm = '0;
  logic       cmd_dest = 1'b0;
  logic [2:0] cmd_bit = '0;
  logic       res_valid;
  logic       res_ready = 1'b1;
  logic [7:0] res_data;
  logic       res_to_acc, res_to_file;
  logic [7:0] acc;
  logic [4:0] flags;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] mw = '0;
  logic [4:0] ms = '0;

  always #5 clk = ~clk;

  acc_alu dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_file(cmd_file), .cmd_imm(cmd_imm), .cmd_dest(cmd_dest),
    .cmd_bit(cmd_bit), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_to_acc(res_to_acc), .res_to_file(res_to_file),
    .acc(acc), .flags(flags)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Reference from requirements R2..R9; flags layout N OV Z DC C (bit 4..0).
  task automatic model(input logic [2:0] op, input logic [7:0] f, input logic [7:0] k,
                       input logic d, input logic [2:0] b,
                       output logic [7:0] r, output logic tw, output logic tf,
                       output logic [4:0] ns);
    logic [8:0] s; logic [4:0] lo; logic [7:0] bo; logic ci;
    ns = ms; tw = 0; tf = 0; r = 0;
    if (op <= 3'd2) begin
      bo = (op == 3'd0) ? k : f;
      ci = (op == 3'd2) ? ms[0] : 1'b0;
      s  = mw + bo + ci;
      lo = mw[3:0] + bo[3:0] + ci;
      r  = s[7:0];
      ns = {r[7], (mw[7] == bo[7]) && (r[7] != mw[7]), r == 0, lo[4], s[8]};
      tw = (op == 3'd0) ? 1'b1 : !d;
      tf = (op == 3'd0) ? 1'b0 : d;
    end else if (op == 3'd3 || op == 3'd4) begin
      bo = (op == 3'd3) ? k : f;
      r  = mw & bo;
      ns[4] = r[7];
      ns[2] = (r == 0);
      tw = (op == 3'd3) ? 1'b1 : !d;
      tf = (op == 3'd3) ? 1'b0 : d;
    end else if (op == 3'd5) begin
      r = f; r[b] = 1'b0; tf = 1;
    end
  endtask

  task automatic run_op(input string req, input logic [2:0] op, input logic [7:0] f,
                        input logic [7:0] k, input logic d, input logic [2:0] b);
    logic [7:0] r; logic tw, tf; logic [4:0] ns;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_file = f; cmd_imm = k; cmd_dest = d; cmd_bit = b;
    res_ready = 1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    model(op, f, k, d, b, r, tw, tf, ns);
    if (tw) mw = r;
    ms = ns;
    chk({req, " valid"}, res_valid, 1);
    chk({req, " data"}, res_data, r);
    chk({req, " to_acc"}, res_to_acc, tw);
    chk({req, " to_file"}, res_to_file, tf);
    chk({req, " acc"}, acc, mw);
    chk({req, " flags"}, flags, ms);
  endtask

  task automatic t_reset();
    chk("R1 acc", acc, 0);
    chk("R1 flags", flags, 0);
    chk("R1 valid", res_valid, 0);
  endtask

  task automatic t_add_imm();
    run_op("R2 add imm", 3'd0, 8'h00, 8'h15, 1'b1, 3'd0);
    run_op("R5 carry+zero", 3'd0, 8'h00, 8'hEB, 1'b0, 3'd0);
  endtask

  task automatic t_add_carry();
    run_op("R4 adc overflow", 3'd2, 8'h7F, 8'h00, 1'b0, 3'd0);
  endtask

  task automatic t_add_file();
    run_op("R3 add to file", 3'd1, 8'h80, 8'h00, 1'b1, 3'd0);
    run_op("R3 add to acc", 3'd1, 8'h01, 8'h00, 1'b0, 3'd0);
  endtask

  task automatic t_and();
    run_op("R6 and imm", 3'd3, 8'h00, 8'hF0, 1'b0, 3'd0);
    run_op("R6 and file", 3'd4, 8'h0F, 8'h00, 1'b1, 3'd0);
    run_op("R6 and to acc", 3'd4, 8'hFF, 8'h00, 1'b0, 3'd0);
  endtask

  task automatic t_bclr();
    run_op("R7 clear b7", 3'd5, 8'hFF, 8'h00, 1'b0, 3'd7);
    run_op("R7 clear b0", 3'd5, 8'h01, 8'h00, 1'b1, 3'd0);
    run_op("R7 clear b3", 3'd5, 8'hAA, 8'h00, 1'b0, 3'd3);
  endtask

  task automatic t_adc_after();
    run_op("R4 adc carry set", 3'd0, 8'h00, 8'hFF, 1'b0, 3'd0);
    run_op("R4 adc uses c", 3'd2, 8'h10, 8'h00, 1'b0, 3'd0);
  endtask

  task automatic t_reserved();
    run_op("R9 reserved 6", 3'd6, 8'h55, 8'h33, 1'b0, 3'd1);
    run_op("R9 reserved 7", 3'd7, 8'hAA, 8'h44, 1'b1, 3'd2);
  endtask

  task automatic t_backpressure();
    logic [7:0] held;
    @(negedge clk);
    res_ready = 0; cmd_valid = 1; cmd_op = 3'd0; cmd_imm = 8'h03; cmd_dest = 0;
    @(posedge clk);
    @(negedge clk);
    mw = mw + 8'h03;
    held = res_data;
    chk("R8 valid held", res_valid, 1);
    chk("R8 ready low", cmd_ready, 0);
    cmd_imm = 8'h05;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 data stable", res_data, held);
      chk("R8 acc untouched", acc, mw);
    end
    res_ready = 1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    mw = mw + 8'h05;
    chk("R8 next accepted", acc, mw);
    chk("R8 next data", res_data, mw);
    ms = flags;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_add_imm();
    t_add_carry();
    t_add_file();
    t_and();
    t_bclr();
    t_adc_after();
    t_reserved();
    t_backpressure();
    run_op("R10 after stall", 3'd1, 8'h22, 8'h00, 1'b1, 3'd0);
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule